// File: doc/BRIEF.md
# OLED Command Sequence Controller

This block produces the control byte streams that set up and steer a 4-bit grayscale OLED panel controller. A host asks for one of five operations: display on, display off, a contrast change, a flip-mode change or a full panel initialisation. The block then plays the matching short command program out of internal tables, one byte per transfer, toward a downstream serial byte sender. Each byte carries a flag that marks it as a command opcode or as an argument. Chip-select framing markers ride on the first and last byte of every request.

The outgoing stream is valid/ready. A byte is transferred in a cycle where both `out_valid` and `out_ready` are high. While `out_ready` is low, the block holds the current byte and all its sideband flags unchanged and does not advance. The host side is a plain pulse interface. A request is taken only while `busy` is low. `done` pulses once when the last byte of the request has been transferred. A flip request also updates the horizontal pixel offset that a separate tile writer reads.

The parameter `PANEL_ROWS` selects the table set: 96 for the 96x96 panel, 128 for the 128x128 panel.

Top module: `oled_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are 0, and `x_offset` is 0.
- R2: Request kind 0 (display on) sends the single command byte 0xAF. Kind 1 (display off) sends the single command byte 0xAE. In both cases that one byte carries `out_cs_start`=1, `out_cs_end`=1 and `out_is_cmd`=1.
- R3: Kind 2 (contrast) sends command 0x81, followed by `req_arg` unchanged (any value 0..255) with `out_is_cmd`=0. `out_cs_start` is set on the first byte and `out_cs_end` on the second.
- R4: Kind 3 (flip) takes the mode from `req_arg` bit 0 and sends four bytes: 0xA2 (cmd), offset (arg), 0xA0 (cmd), remap (arg). For the 96x96 panel, mode 0 uses offset 0x20 and remap 0x51, and mode 1 uses offset 0x60 and remap 0x42. For the 128x128 panel, the offset is 0x00 in both modes.
- R5: When a flip request completes, `x_offset` takes the panel's offset for the chosen mode: 16 for both modes on the 96x96 panel, 0 on the 128x128 panel. It changes only in the cycle where `done` is high.
- R6: Kind 4 (init) sends 29 bytes, given here as cmd/arg groups: FD 12, AE, A8 5F, A1 00, A2 20, A0 51, AB 01, 81 53, B1 51, B3 01, B9, BC 08, BE 07, B6 01, D5 62, A4. The 128x128 panel uses 7F in place of 5F and 00 in place of 20. Only the first byte of each group is flagged as a command.
- R7: While `out_valid`=1 and `out_ready`=0, the byte and its flags stay stable. Every byte is transferred exactly once, in order.
- R8: A request made while `busy`=1 is ignored. A request with kind 5, 6 or 7 is ignored: no byte is sent and `busy` stays 0.
- R9: `done` is high for exactly one cycle. That cycle is the one after the transfer of the byte marked `out_cs_end`, and `busy` is 0 in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_kind | input | 3 | Request kind: 0 on, 1 off, 2 contrast, 3 flip, 4 init |
| req_arg | input | 8 | Contrast value, or flip mode in bit 0 |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| x_offset | output | 8 | Horizontal pixel offset for the tile writer |
| out_valid | output | 1 | Outgoing byte is valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | Command or argument byte |
| out_is_cmd | output | 1 | Byte is a command opcode |
| out_cs_start | output | 1 | First byte of a chip-select frame |
| out_cs_end | output | 1 | Last byte of a chip-select frame |

## Verification
The properties assume the downstream sender may drop `out_ready` in any cycle. They also assume the host may raise `req_valid` at any time, including while a request is running. Nothing is assumed about how long `out_ready` stays low. The stimulus drives all inputs on the falling edge. It applies free-running pseudo-random back-pressure during contrast, display-off and init transfers, and holds `out_ready` low on purpose to create a busy window for the ignored-request case. Request arguments cover the contrast extremes and a flip argument with spare upper bits set.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;
  localparam int IDX_W    = 5;
  localparam int INIT_LEN = 29;

  typedef enum logic [2:0] {
    K_PWR_ON   = 3'd0,
    K_PWR_OFF  = 3'd1,
    K_CONTRAST = 3'd2,
    K_FLIP     = 3'd3,
    K_INIT     = 3'd4
  } req_kind_e;

  typedef struct packed {
    logic [7:0] val;
    logic       is_cmd;
  } seq_beat_t;

  function automatic logic kind_ok(input logic [2:0] k);
    return k <= 3'd4;
  endfunction
endpackage

// File: rtl/oled_seq_table.sv
module oled_seq_table
  import oled_seq_pkg::*;
#(
  parameter int PANEL_ROWS = 96
) (
  input  req_kind_e              kind,
  input  logic [7:0]             arg,
  input  logic [IDX_W-1:0]       idx,
  output seq_beat_t              beat,
  output logic                   last
);
  localparam logic [7:0] MUX_RATIO = 8'(PANEL_ROWS - 1);
  localparam logic [7:0] OFFS_M0   = (PANEL_ROWS == 128) ? 8'h00 : 8'h20;
  localparam logic [7:0] OFFS_M1   = (PANEL_ROWS == 128) ? 8'h00 : 8'h60;

  function automatic seq_beat_t c(input logic [7:0] v);
    return '{val: v, is_cmd: 1'b1};
  endfunction

  function automatic seq_beat_t a(input logic [7:0] v);
    return '{val: v, is_cmd: 1'b0};
  endfunction

  function automatic seq_beat_t init_beat(input logic [IDX_W-1:0] i);
    case (i)
      5'd0:    return c(8'hFD);
      5'd1:    return a(8'h12);
      5'd2:    return c(8'hAE);
      5'd3:    return c(8'hA8);
      5'd4:    return a(MUX_RATIO);
      5'd5:    return c(8'hA1);
      5'd6:    return a(8'h00);
      5'd7:    return c(8'hA2);
      5'd8:    return a(OFFS_M0);
      5'd9:    return c(8'hA0);
      5'd10:   return a(8'h51);
      5'd11:   return c(8'hAB);
      5'd12:   return a(8'h01);
      5'd13:   return c(8'h81);
      5'd14:   return a(8'h53);
      5'd15:   return c(8'hB1);
      5'd16:   return a(8'h51);
      5'd17:   return c(8'hB3);
      5'd18:   return a(8'h01);
      5'd19:   return c(8'hB9);
      5'd20:   return c(8'hBC);
      5'd21:   return a(8'h08);
      5'd22:   return c(8'hBE);
      5'd23:   return a(8'h07);
      5'd24:   return c(8'hB6);
      5'd25:   return a(8'h01);
      5'd26:   return c(8'hD5);
      5'd27:   return a(8'h62);
      default: return c(8'hA4);
    endcase
  endfunction

  logic [IDX_W-1:0] len;

  always_comb begin
    beat = a(8'h00);
    len  = IDX_W'(1);
    case (kind)
      K_PWR_ON:  beat = c(8'hAF);
      K_PWR_OFF: beat = c(8'hAE);
      K_CONTRAST: begin
        len  = IDX_W'(2);
        beat = (idx == '0) ? c(8'h81) : a(arg);
      end
      K_FLIP: begin
        len = IDX_W'(4);
        case (idx[1:0])
          2'd0:    beat = c(8'hA2);
          2'd1:    beat = a(arg[0] ? OFFS_M1 : OFFS_M0);
          2'd2:    beat = c(8'hA0);
          default: beat = a(arg[0] ? 8'h42 : 8'h51);
        endcase
      end
      K_INIT: begin
        len  = IDX_W'(INIT_LEN);
        beat = init_beat(idx);
      end
      default: beat = a(8'h00);
    endcase
    last = (idx == len - IDX_W'(1));
  end
endmodule

// File: rtl/oled_xoff_reg.sv
module oled_xoff_reg #(
  parameter int          W        = 8,
  parameter logic [W-1:0] OFF_DEF  = '0,
  parameter logic [W-1:0] OFF_FLIP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         flip_mode,
  output logic [W-1:0] x_offset
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      x_offset <= '0;
    else if (load)
      x_offset <= flip_mode ? OFF_FLIP : OFF_DEF;
  end
endmodule

// File: rtl/oled_cmd_seq.sv
module oled_cmd_seq
  import oled_seq_pkg::*;
#(
  parameter int PANEL_ROWS = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  input  logic [7:0] req_arg,
  output logic       busy,
  output logic       done,
  output logic [7:0] x_offset,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte,
  output logic       out_is_cmd,
  output logic       out_cs_start,
  output logic       out_cs_end
);
  localparam logic [7:0] XOFF_DEF  = (PANEL_ROWS == 128) ? 8'd0 : 8'd16;
  localparam logic [7:0] XOFF_FLIP = (PANEL_ROWS == 128) ? 8'd0 : 8'd16;

  logic             active_q;
  req_kind_e        kind_q;
  logic [7:0]       arg_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  seq_beat_t        beat;
  logic             last;
  logic             accept;
  logic             fire;

  assign accept = req_valid && !active_q && kind_ok(req_kind);
  assign fire   = active_q && out_ready;

  oled_seq_table #(.PANEL_ROWS(PANEL_ROWS)) u_table (
    .kind (kind_q),
    .arg  (arg_q),
    .idx  (idx_q),
    .beat (beat),
    .last (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      kind_q   <= K_PWR_ON;
      arg_q    <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fire && last;
      if (accept) begin
        active_q <= 1'b1;
        kind_q   <= req_kind_e'(req_kind);
        arg_q    <= req_arg;
        idx_q    <= '0;
      end else if (fire) begin
        if (last) active_q <= 1'b0;
        else      idx_q    <= idx_q + IDX_W'(1);
      end
    end
  end

  oled_xoff_reg #(.W(8), .OFF_DEF(XOFF_DEF), .OFF_FLIP(XOFF_FLIP)) u_xoff (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire && last && (kind_q == K_FLIP)),
    .flip_mode (arg_q[0]),
    .x_offset  (x_offset)
  );

  assign busy         = active_q;
  assign done         = done_q;
  assign out_valid    = active_q;
  assign out_byte     = beat.val;
  assign out_is_cmd   = beat.is_cmd;
  assign out_cs_start = active_q && (idx_q == '0);
  assign out_cs_end   = active_q && last;
endmodule

// File: rtl/oled_cmd_seq_chk.sv
module oled_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic [7:0] x_offset,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_is_cmd,
  input logic       out_cs_start,
  input logic       out_cs_end
);
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_is_cmd)
      && $stable(out_cs_start) && $stable(out_cs_end));

  a_r9_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_cs_end |=> done && !busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_start_is_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cs_start |-> out_is_cmd);

  a_r5_xoff_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(x_offset) |-> done);

  a_r8_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

bind oled_cmd_seq oled_cmd_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .busy         (busy),
  .done         (done),
  .x_offset     (x_offset),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_byte     (out_byte),
  .out_is_cmd   (out_is_cmd),
  .out_cs_start (out_cs_start),
  .out_cs_end   (out_cs_end)
);

// File: tb/oled_cmd_seq_bench.sv
module oled_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [7:0] req_arg = '0;
  logic       busy, done, out_valid, out_is_cmd, out_cs_start, out_cs_end;
  logic [7:0] x_offset, out_byte;
  logic       out_ready = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int         rdy_mode = 0;  // 0 always ready, 1 pseudo-random, 2 held low
  logic [7:0] lfsr = 8'hA5;

  logic [10:0] cap [0:63];
  int          cap_n = 0;
  logic [8:0]  exp_q [0:63];
  int          exp_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oled_cmd_seq u_oled_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_arg(req_arg), .busy(busy), .done(done), .x_offset(x_offset),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_is_cmd(out_is_cmd), .out_cs_start(out_cs_start), .out_cs_end(out_cs_end)
  );

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready && cap_n < 64) begin
      cap[cap_n] = {out_cs_start, out_cs_end, out_is_cmd, out_byte};
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] v, input logic cmd);
    exp_q[exp_n] = {cmd, v};
    exp_n++;
  endtask

  task automatic compare(input string req);
    int bad = -1;
    check({req, " length"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      logic [10:0] e;
      e = {(i == 0), (i == exp_n - 1), exp_q[i]};
      if (bad < 0 && cap[i] != e) bad = i;
    end
    if (bad >= 0) check({req, " content"}, int'(cap[bad]), int'({(bad == 0), (bad == exp_n - 1), exp_q[bad]}));
    else          check({req, " content"}, 0, 0);
  endtask

  task automatic run_req(input string req, input logic [2:0] k, input logic [7:0] arg);
    int t = 0;
    cap_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_arg = arg;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check({req, " R9 done seen"}, int'(done), 1);
    check({req, " R9 busy low at done"}, int'(busy), 0);
    @(negedge clk);
    check({req, " R9 done one cycle"}, int'(done), 0);
  endtask

  task automatic t_reset;
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 x_offset", int'(x_offset), 0);
  endtask

  task automatic t_power;
    rdy_mode = 0;
    exp_n = 0; push(8'hAF, 1);
    run_req("R2 on", 3'd0, 8'h00); compare("R2 on");
    rdy_mode = 1;
    exp_n = 0; push(8'hAE, 1);
    run_req("R2 off", 3'd1, 8'h00); compare("R2 off R7");
  endtask

  task automatic t_contrast;
    rdy_mode = 1;
    exp_n = 0; push(8'h81, 1); push(8'h00, 0);
    run_req("R3 min", 3'd2, 8'h00); compare("R3 min R7");
    exp_n = 0; push(8'h81, 1); push(8'hFF, 0);
    run_req("R3 max", 3'd2, 8'hFF); compare("R3 max R7");
  endtask

  task automatic t_flip;
    rdy_mode = 0;
    exp_n = 0; push(8'hA2, 1); push(8'h20, 0); push(8'hA0, 1); push(8'h51, 0);
    run_req("R4 mode0", 3'd3, 8'h00); compare("R4 mode0");
    check("R5 x_offset mode0", int'(x_offset), 16);
    exp_n = 0; push(8'hA2, 1); push(8'h60, 0); push(8'hA0, 1); push(8'h42, 0);
    run_req("R4 mode1", 3'd3, 8'hF3); compare("R4 mode1");
    check("R5 x_offset mode1", int'(x_offset), 16);
  endtask

  task automatic t_init;
    rdy_mode = 1;
    exp_n = 0;
    push(8'hFD, 1); push(8'h12, 0); push(8'hAE, 1);
    push(8'hA8, 1); push(8'h5F, 0); push(8'hA1, 1); push(8'h00, 0);
    push(8'hA2, 1); push(8'h20, 0); push(8'hA0, 1); push(8'h51, 0);
    push(8'hAB, 1); push(8'h01, 0); push(8'h81, 1); push(8'h53, 0);
    push(8'hB1, 1); push(8'h51, 0); push(8'hB3, 1); push(8'h01, 0);
    push(8'hB9, 1); push(8'hBC, 1); push(8'h08, 0); push(8'hBE, 1); push(8'h07, 0);
    push(8'hB6, 1); push(8'h01, 0); push(8'hD5, 1); push(8'h62, 0); push(8'hA4, 1);
    run_req("R6 init", 3'd4, 8'h00); compare("R6 init R7");
  endtask

  task automatic t_busy_ignore;
    int t = 0;
    rdy_mode = 2;
    cap_n = 0;
    exp_n = 0; push(8'hAF, 1);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd0; req_arg = 8'h00;
    @(negedge clk);
    req_kind = 3'd2; req_arg = 8'h77;
    check("R8 busy during stall", int'(busy), 1);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rdy_mode = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    check("R8 no second request", int'(busy), 0);
    compare("R8 ignored while busy");
  endtask

  task automatic t_bad_kind;
    rdy_mode = 0;
    for (int k = 5; k < 8; k++) begin
      cap_n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(k); req_arg = 8'h01;
      @(negedge clk);
      req_valid = 1'b0;
      check("R8 bad kind busy", int'(busy), 0);
      repeat (3) @(negedge clk);
      check("R8 bad kind bytes", cap_n, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_power();
    t_contrast();
    t_flip();
    t_init();
    t_busy_ignore();
    t_bad_kind();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired R9 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule